// File: doc/BRIEF.md
# Double-Error BCH(15,7) Decoder

This block repairs a 15-bit word taken from a double-error-correcting binary BCH(15,7) channel. Each received word enters through a valid/ready input. The block computes the odd syndromes over GF(16). It forms the error-locator polynomial from the closed-form Peterson solution for two errors, and then tests one field element per clock to locate the flipped bits. The repaired word, its seven message bits and an uncorrectable flag leave through a valid/ready output.

Only one word is in flight at a time. The input stays not-ready from the accepting edge until the result has been taken. The output holds the result, unchanged, for as long as the consumer keeps ready low. Delay through the block does not depend on the data or on the error count.

Top module: `bch2_decoder`

## Requirements
- R1: While reset is held and just after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the output handshake completes, and it is 1 again in the cycle after that handshake.
- R3: `out_valid` goes high on the 16th rising edge after the accepting edge, whatever the data.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_word`, `out_msg` and `out_uncorr` stay unchanged. The result is consumed on an edge where both are 1, and `out_valid` is 0 in the following cycle.
- R5: Bit l of a word is the coefficient of x^l. Codewords are the multiples of g(x) = x^8+x^7+x^6+x^4+1, which places the message in bits 14..8, and field arithmetic uses x^4+x+1. A codeword leaves unchanged with `out_uncorr` 0.
- R6: A codeword with any one bit flipped is restored exactly, with `out_uncorr` 0.
- R7: A codeword with any two bits flipped is restored exactly, with `out_uncorr` 0.
- R8: `out_msg` equals bits 14..8 of `out_word`.
- R9: If S1 = 0 while S3 is nonzero, `out_uncorr` is 1 and `out_word` equals the received word.
- R10: If the number of locator roots found differs from the locator degree, `out_uncorr` is 1 and `out_word` equals the received word.
- R11: A word with more than two errors that lies within Hamming distance 2 of some codeword is output as that codeword, with `out_uncorr` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received word present |
| in_ready | output | 1 | Block idle, able to take a word |
| in_word | input | 15 | Received word, bit l = coefficient of x^l |
| out_valid | output | 1 | Result present (done) |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 15 | Corrected word, or the received word when uncorrectable |
| out_msg | output | 7 | Message bits, out_word[14:8] |
| out_uncorr | output | 1 | Error pattern beyond correction |

## Verification
The bench sweeps every single and double error position over varied messages, because a wrong syndrome power or locator shift shows up as a bit repaired in the wrong place. Every triple-error pattern is applied as well. Those words either sit near another codeword, where a flawed decoder wrongly flags them, or lie near no codeword, where a decoder that ignores the S1 = 0 case or the root-count mismatch emits a corrupted word with the flag low. Some vectors hold `out_ready` low to catch a design that drops or alters the held result. The latency count catches an off-by-one in the search length.

// File: rtl/bch2_pkg.sv
package bch2_pkg;
  localparam int GF_M   = 4;
  localparam logic [GF_M:0] GF_POLY = 5'b10011;
  localparam int CW_N   = (1 << GF_M) - 1;
  localparam int CW_T   = 2;
  localparam int CW_K   = CW_N - GF_M * CW_T;
  localparam int ROOT_W = $clog2(CW_N + 1);
  localparam int POS_W  = $clog2(CW_N);
  localparam int LATENCY = CW_N + 1;

  typedef logic [GF_M-1:0] gf_t;
  typedef logic [CW_N-1:0] cw_t;
  typedef enum logic [1:0] {DEC_IDLE, DEC_SOLVE, DEC_SEARCH, DEC_HOLD} dec_state_e;

  // product of two field elements, shift-and-reduce
  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc ^= sh;
      if (sh[GF_M-1]) sh = {sh[GF_M-2:0], 1'b0} ^ GF_POLY[GF_M-1:0];
      else            sh = {sh[GF_M-2:0], 1'b0};
    end
    return acc;
  endfunction

  // alpha raised to e (fixed loop bound)
  function automatic gf_t gf_pow_alpha(int e);
    gf_t v;
    int  r;
    v = gf_t'(1);
    r = e % CW_N;
    for (int i = 0; i < CW_N; i++)
      if (i < r) v = gf_mul(v, gf_t'(2));
    return v;
  endfunction

  // inverse as a^(N-1); zero maps to zero
  function automatic gf_t gf_inv(gf_t a);
    gf_t v;
    v = gf_t'(1);
    for (int i = 0; i < CW_N - 1; i++) v = gf_mul(v, a);
    return v;
  endfunction

  // word evaluated at alpha^pw
  function automatic gf_t cw_syndrome(cw_t w, int pw);
    gf_t s;
    s = '0;
    for (int l = 0; l < CW_N; l++)
      if (w[l]) s ^= gf_pow_alpha(pw * l);
    return s;
  endfunction
endpackage

// File: rtl/bch2_syndrome.sv
module bch2_syndrome
  import bch2_pkg::*;
(
  input  logic [CW_N-1:0] word_i,
  output logic [GF_M-1:0] s1_o,
  output logic [GF_M-1:0] s3_o
);
  gf_t term1 [CW_N];
  gf_t term3 [CW_N];

  for (genvar l = 0; l < CW_N; l++) begin : g_term
    localparam gf_t A1 = gf_pow_alpha(l);
    localparam gf_t A3 = gf_pow_alpha(3 * l);
    assign term1[l] = word_i[l] ? A1 : '0;
    assign term3[l] = word_i[l] ? A3 : '0;
  end

  always_comb begin
    s1_o = '0;
    s3_o = '0;
    for (int l = 0; l < CW_N; l++) begin
      s1_o ^= term1[l];
      s3_o ^= term3[l];
    end
  end
endmodule

// File: rtl/bch2_locator.sv
module bch2_locator
  import bch2_pkg::*;
(
  input  logic [GF_M-1:0] s1_i,
  input  logic [GF_M-1:0] s3_i,
  output logic [GF_M-1:0] sig1_o,
  output logic [GF_M-1:0] sig2_o,
  output logic [1:0]      deg_o,
  output logic            bad_o
);
  gf_t s1_sq, s1_cube, diff, s1_inv;

  assign s1_sq   = gf_mul(s1_i, s1_i);
  assign s1_cube = gf_mul(s1_sq, s1_i);
  assign diff    = s3_i ^ s1_cube;
  assign s1_inv  = gf_inv(s1_i);

  always_comb begin
    sig1_o = s1_i;
    sig2_o = '0;
    deg_o  = 2'd0;
    bad_o  = 1'b0;
    if (s1_i == '0) begin
      bad_o = (s3_i != '0);
    end else if (diff == '0) begin
      deg_o = 2'd1;
    end else begin
      deg_o  = 2'd2;
      sig2_o = gf_mul(diff, s1_inv);
    end
  end
endmodule

// File: rtl/bch2_chien.sv
module bch2_chien
  import bch2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [GF_M-1:0]   sig1_i,
  input  logic [GF_M-1:0]   sig2_i,
  output logic [CW_N-1:0]   err_o,
  output logic [ROOT_W-1:0] roots_o,
  output logic              last_o
);
  localparam gf_t STEP1 = gf_pow_alpha(CW_N - 1);
  localparam gf_t STEP2 = gf_pow_alpha(CW_N - 2);

  gf_t              t1_q, t2_q;
  logic [POS_W-1:0] pos_q;
  logic             hit;

  assign hit    = ((gf_t'(1) ^ t1_q ^ t2_q) == '0);
  assign last_o = step_i && (pos_q == POS_W'(CW_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_q    <= '0;
      t2_q    <= '0;
      pos_q   <= '0;
      err_o   <= '0;
      roots_o <= '0;
    end else if (load_i) begin
      t1_q    <= sig1_i;
      t2_q    <= sig2_i;
      pos_q   <= '0;
      err_o   <= '0;
      roots_o <= '0;
    end else if (step_i) begin
      if (hit) begin
        err_o[pos_q] <= 1'b1;
        roots_o      <= roots_o + 1'b1;
      end
      t1_q  <= gf_mul(t1_q, STEP1);
      t2_q  <= gf_mul(t2_q, STEP2);
      pos_q <= pos_q + 1'b1;
    end
  end

  // R10
  roots_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roots_o <= ROOT_W'(CW_T));

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> pos_q <= POS_W'(CW_N - 1));
endmodule

// File: rtl/bch2_decoder.sv
module bch2_decoder
  import bch2_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CW_N-1:0] in_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CW_N-1:0] out_word,
  output logic [CW_K-1:0] out_msg,
  output logic            out_uncorr
);
  localparam int LAT_W = $clog2(LATENCY + 2);

  dec_state_e        state_q;
  cw_t               rx_q;
  logic [1:0]        deg_q;
  logic              bad_q;
  gf_t               s1, s3, sig1, sig2;
  logic [1:0]        deg;
  logic              bad;
  cw_t               err_vec;
  logic [ROOT_W-1:0] roots;
  logic              last;
  logic              take;

  assign in_ready  = (state_q == DEC_IDLE);
  assign out_valid = (state_q == DEC_HOLD);
  assign take      = in_valid && in_ready;

  bch2_syndrome u_syn (
    .word_i (rx_q),
    .s1_o   (s1),
    .s3_o   (s3)
  );

  bch2_locator u_loc (
    .s1_i   (s1),
    .s3_i   (s3),
    .sig1_o (sig1),
    .sig2_o (sig2),
    .deg_o  (deg),
    .bad_o  (bad)
  );

  bch2_chien u_chien (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (state_q == DEC_SOLVE),
    .step_i  (state_q == DEC_SEARCH),
    .sig1_i  (sig1),
    .sig2_i  (sig2),
    .err_o   (err_vec),
    .roots_o (roots),
    .last_o  (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DEC_IDLE;
      rx_q    <= '0;
      deg_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      unique case (state_q)
        DEC_IDLE: if (in_valid) begin
          rx_q    <= in_word;
          state_q <= DEC_SOLVE;
        end
        DEC_SOLVE: begin
          deg_q   <= deg;
          bad_q   <= bad;
          state_q <= DEC_SEARCH;
        end
        DEC_SEARCH: if (last) state_q <= DEC_HOLD;
        DEC_HOLD:   if (out_ready) state_q <= DEC_IDLE;
        default:    state_q <= DEC_IDLE;
      endcase
    end
  end

  assign out_uncorr = bad_q || (roots != ROOT_W'(deg_q));
  assign out_word   = out_uncorr ? rx_q : (rx_q ^ err_vec);
  assign out_msg    = out_word[CW_N-1 -: CW_K];

  // cycles since the accepting edge, used only by the latency check
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            lat_q <= '0;
    else if (take)                         lat_q <= '0;
    else if (!out_valid && lat_q != '1)    lat_q <= lat_q + 1'b1;
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready && !out_valid);

  // R3
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == LAT_W'(LATENCY));

  // R4
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_uncorr));

  // R7
  repaired_is_codeword_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_uncorr |-> cw_syndrome(out_word, 1) == '0 && cw_syndrome(out_word, 3) == '0);
endmodule

// File: tb/bch2_decoder_bench.sv
module bch2_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [14:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [14:0] out_word;
  logic [6:0]  out_msg;
  logic        out_uncorr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bch2_decoder u_bch2_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_msg(out_msg), .out_uncorr(out_uncorr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // systematic encoder: remainder of m(x)*x^8 by g = 0x1D1
  function automatic logic [14:0] enc(logic [6:0] m);
    logic [14:0] v;
    v = {m, 8'b0};
    for (int i = 14; i >= 8; i--)
      if (v[i]) v ^= (15'(9'h1D1) << (i - 8));
    return {m, v[7:0]};
  endfunction

  function automatic logic [3:0] xt(logic [3:0] v);
    return {v[2:0], 1'b0} ^ (v[3] ? 4'h3 : 4'h0);
  endfunction

  function automatic logic [3:0] s1_of(logic [14:0] r);
    logic [3:0] s, a;
    s = '0; a = 4'h1;
    for (int l = 0; l < 15; l++) begin
      if (r[l]) s ^= a;
      a = xt(a);
    end
    return s;
  endfunction

  // nearest codeword within distance 2, by exhaustive search
  task automatic nearest(input logic [14:0] r, output bit found, output logic [14:0] cw);
    found = 1'b0; cw = r;
    for (int m = 0; m < 128; m++) begin
      logic [14:0] c;
      c = enc(7'(m));
      if ($countones(c ^ r) <= 2) begin found = 1'b1; cw = c; end
    end
  endtask

  task automatic apply(input logic [14:0] r, input bit stall, input int wt);
    bit          found, busy_ok;
    logic [14:0] expw, held;
    string       tag;
    int          n;
    nearest(r, found, expw);
    if      (wt == 0) tag = "R5";
    else if (wt == 1) tag = "R6";
    else if (wt == 2) tag = "R7";
    else if (found)   tag = "R11";
    else if (s1_of(r) == 4'h0) tag = "R9";
    else              tag = "R10";
    in_word = r; in_valid = 1'b1; out_ready = !stall;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0; busy_ok = 1'b1;
    while (!out_valid && n < 40) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    check(n == 16, "R3 latency", 32'(n), 32'd16);
    check(busy_ok, "R2 busy", 32'(busy_ok), 32'd1);
    check({out_uncorr, out_word} == {!found, expw}, tag,
          32'({out_uncorr, out_word}), 32'({!found, expw}));
    check(out_msg == expw[14:8], "R8", 32'(out_msg), 32'(expw[14:8]));
    if (stall) begin
      held = out_word;
      repeat (3) @(negedge clk);
      check(out_valid && out_word == held && !in_ready, "R4 hold",
            32'({out_valid, out_word}), 32'({1'b1, held}));
      out_ready = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready, "R4 release", 32'({out_valid, in_ready}), 32'b01);
    end else begin
      @(negedge clk);
      check(!out_valid && in_ready, "R2 idle", 32'({out_valid, in_ready}), 32'b01);
    end
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1
    check(in_ready && !out_valid, "R1 in reset", 32'({in_ready, out_valid}), 32'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !out_valid, "R1 after reset", 32'({in_ready, out_valid}), 32'b10);

    for (int m = 0; m < 128; m++) apply(enc(7'(m)), (m % 16) == 3, 0);
    for (int p = 0; p < 15; p++)
      apply(enc(7'((p * 37 + 5) % 128)) ^ (15'(1) << p), (p % 5) == 0, 1);
    k = 0;
    for (int a = 0; a < 15; a++)
      for (int b = a + 1; b < 15; b++) begin
        apply(enc(7'((k * 53 + 11) % 128)) ^ (15'(1) << a) ^ (15'(1) << b), (k % 11) == 0, 2);
        k++;
      end
    k = 0;
    for (int a = 0; a < 15; a++)
      for (int b = a + 1; b < 15; b++)
        for (int c = b + 1; c < 15; c++) begin
          apply(enc(7'((k * 29 + 3) % 128)) ^ (15'(1) << a) ^ (15'(1) << b) ^ (15'(1) << c),
                (k % 37) == 0, 3);
          k++;
        end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule